// File: doc/BRIEF.md
# 6502 Bus Instruction Injector

This block stands in for program memory on the data bus of a 6502-family CPU. It follows the CPU's bus cycles by sampling the CPU clock output and the read/write pin, both synchronised into the system clock. On every read cycle it drives the byte the CPU should see at that point. On every write cycle it releases the bus and captures the byte the CPU writes.

A host hands it one instruction at a time over a valid/ready handshake. Each instruction is an opcode, up to two operand bytes and a byte count. The block covers immediate, zero-page and absolute instructions. It plays each one out with the bus cycles its addressing family needs. While nothing is pending it feeds a zero-page store as filler, so the CPU repeats a fixed three-cycle pattern.

Because the program counter never points at real memory, the block also resets the CPU at a configurable period. It holds off new work while that reset and the following vector fetch are in progress.

Top module: `bus_injector`

## Requirements
- R1: While and right after the system reset, `cpu_rst_n` is low, the data drivers are off, `host_ready` is low, and `busy` and `err` are low.
- R2: A CPU reset lasts exactly `RST_HOLD` bus cycles. It is followed by `PRE_CYC` read cycles. The next two reads return `VEC[7:0]` and then `VEC[15:8]`.
- R3: With no instruction pending, the block feeds the filler store: a read returning 0x85, a read returning `IDLE_ZP`, then a write cycle.
- R4: On every write cycle (`cpu_rnw` low) the drivers are off. At the end of that cycle `cap_stb` pulses once, `cap_data` holds the CPU byte, and `cap_addr` holds the address last injected: {0x00, zero-page byte} or {high byte, low byte}.
- R5: An immediate instruction (for example 0xA9 load, 0x49 exclusive OR) takes two read cycles, opcode then `host_arg0`. Sending 0xA9 0x01 and then 0x49 0xFF makes the next store write 0xFE.
- R6: A zero-page instruction (for example 0xA5) takes three cycles: opcode, `host_arg0` as the address, then one data cycle. When that data cycle is a read, it returns the last captured write byte.
- R7: An absolute instruction (for example 0x8D store) takes four cycles: opcode, `host_arg0` (low byte), `host_arg1` (high byte), then one data cycle.
- R8: At least two complete filler instructions run before every host instruction. This holds both after the previous host instruction and after a CPU reset.
- R9: `host_ready` is low while an instruction is pending and during a CPU reset or vector fetch. `busy` rises when an instruction is accepted and falls when its last bus cycle ends.
- R10: The `host_len` field carries the byte count: 2 for immediate and zero-page, 3 for absolute. An unrecognised opcode (for example 0x02) or a byte count that does not match the opcode sets `err` and drops the request, so only filler reaches the bus. The next accepted valid request clears `err`.
- R11: A CPU reset is asserted when at least `RST_PERIOD` bus cycles have run since the last release. It is asserted only at the end of a filler store cycle, never inside a host instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the CPU clock |
| rst_n | input | 1 | Active-low system reset |
| cpu_phi2 | input | 1 | CPU clock output (asynchronous) |
| cpu_rnw | input | 1 | CPU read/write pin, high for read |
| cpu_d_in | input | 8 | Data bus as seen from the CPU side |
| cpu_d_out | output | 8 | Byte driven onto the data bus |
| cpu_d_oe | output | 1 | Data bus driver enable |
| cpu_rst_n | output | 1 | Active-low reset to the CPU |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can take a request |
| host_op | input | 8 | Opcode |
| host_arg0 | input | 8 | First operand byte |
| host_arg1 | input | 8 | Second operand byte |
| host_len | input | 2 | Instruction length in bytes |
| busy | output | 1 | An accepted instruction is not finished |
| err | output | 1 | Last request was rejected |
| cap_stb | output | 1 | One-clock pulse per captured write |
| cap_data | output | 8 | Last byte written by the CPU |
| cap_addr | output | 16 | Address tag of the last captured write |

## Verification
The bench models the CPU at bus level. It decodes each fetched opcode itself, keeps its own accumulator, and chooses read or write per cycle. Because of this, any wrong byte, wrong cycle count or misplaced direction shows up as a desynchronised stream. Streams of filler alone check the idle pattern and the capture tags. A chained immediate load and exclusive OR separate correct operand delivery from stale data. A zero-page load after a store separates the data-cycle source from the operand path. An absolute store checks the two-byte address tag. Rejected opcodes and wrong byte counts, followed by a valid request, check that the error flag sets and clears. A short reset period forces several periodic resets in the middle of traffic, which checks the reset window, the hold length and the vector bytes.

// File: rtl/inj_pkg.sv
package inj_pkg;

   typedef enum logic [1:0] {
      FAM_NONE,
      FAM_IMM,
      FAM_ZP,
      FAM_ABS
   } fam_t;

   typedef enum logic [3:0] {
      S_RST, S_PRE, S_VLO, S_VHI,
      S_IOP, S_IZP, S_IWR,
      S_OP,  S_B1,  S_B2,  S_DAT
   } seq_t;

   localparam logic [7:0] FILL_OP = 8'h85;

   function automatic logic [1:0] fam_bytes(input fam_t f);
      case (f)
         FAM_ABS: fam_bytes = 2'd3;
         FAM_NONE: fam_bytes = 2'd0;
         default: fam_bytes = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/inj_opdecode.sv
module inj_opdecode
   import inj_pkg::*;
(
   input  logic [7:0] op,
   output fam_t       fam
);
   logic [2:0] grp_a;
   logic [2:0] mode_b;
   logic [1:0] cls_c;

   assign grp_a  = op[7:5];
   assign mode_b = op[4:2];
   assign cls_c  = op[1:0];

   always_comb begin
      fam = FAM_NONE;
      case (cls_c)
         2'b01: begin
            if (mode_b == 3'b001)                     fam = FAM_ZP;
            else if (mode_b == 3'b011)                fam = FAM_ABS;
            else if (mode_b == 3'b010 && op != 8'h89) fam = FAM_IMM;
         end
         2'b00: begin
            if (grp_a[2]) begin
               if (mode_b == 3'b001)                     fam = FAM_ZP;
               else if (mode_b == 3'b011)                fam = FAM_ABS;
               else if (mode_b == 3'b000 && grp_a != 3'b100) fam = FAM_IMM;
            end
         end
         2'b10: begin
            if (grp_a == 3'b100 || grp_a == 3'b101) begin
               if (mode_b == 3'b001)      fam = FAM_ZP;
               else if (mode_b == 3'b011) fam = FAM_ABS;
               else if (mode_b == 3'b000 && grp_a == 3'b101) fam = FAM_IMM;
            end
         end
         default: fam = FAM_NONE;
      endcase
   end
endmodule

// File: rtl/inj_rst_timer.sv
module inj_rst_timer #(
   parameter int unsigned PERIOD = 100000,
   parameter int unsigned HOLD   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_end,
   input  logic at_boundary,
   output logic cpu_rst_n
);
   localparam int RW = $clog2(PERIOD + 1);
   localparam int HW = $clog2(HOLD + 1);

   generate
      if (PERIOD < 16) begin : g_bad_period
         $error("inj_rst_timer: PERIOD must be at least 16");
      end
      if (HOLD < 1) begin : g_bad_hold
         $error("inj_rst_timer: HOLD must be at least 1");
      end
   endgenerate

   logic [RW-1:0] run_cnt;
   logic [RW:0]   run_nxt;
   logic [HW-1:0] hold_cnt;

   assign run_nxt = {1'b0, run_cnt} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_rst_n <= 1'b0;
         hold_cnt  <= '0;
         run_cnt   <= '0;
      end else if (cyc_end) begin
         if (!cpu_rst_n) begin
            if (hold_cnt == HW'(HOLD - 1)) begin
               cpu_rst_n <= 1'b1;
               hold_cnt  <= '0;
               run_cnt   <= '0;
            end else begin
               hold_cnt <= hold_cnt + 1'b1;
            end
         end else if (at_boundary && run_nxt >= (RW+1)'(PERIOD)) begin
            cpu_rst_n <= 1'b0;
         end else if (run_cnt != RW'(PERIOD)) begin
            run_cnt <= run_nxt[RW-1:0];
         end
      end
   end

   AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rst_n |-> (hold_cnt < HW'(HOLD))); // R2
endmodule

// File: rtl/bus_injector.sv
module bus_injector
   import inj_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_PERIOD  = 100000,
   parameter int unsigned RST_HOLD    = 8,
   parameter int unsigned PRE_CYC     = 5,
   parameter logic [15:0] VEC         = 16'hF000,
   parameter logic [7:0]  IDLE_ZP     = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cpu_phi2,
   input  logic        cpu_rnw,
   input  logic [7:0]  cpu_d_in,
   output logic [7:0]  cpu_d_out,
   output logic        cpu_d_oe,
   output logic        cpu_rst_n,
   input  logic        host_valid,
   output logic        host_ready,
   input  logic [7:0]  host_op,
   input  logic [7:0]  host_arg0,
   input  logic [7:0]  host_arg1,
   input  logic [1:0]  host_len,
   output logic        busy,
   output logic        err,
   output logic        cap_stb,
   output logic [7:0]  cap_data,
   output logic [15:0] cap_addr
);
   localparam int PW = $clog2(PRE_CYC + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bus_injector: SYNC_STAGES must be at least 2");
      end
      if (PRE_CYC < 1) begin : g_bad_pre
         $error("bus_injector: PRE_CYC must be at least 1");
      end
   endgenerate

   // clock-domain crossing of the CPU clock and R/W pin
   logic [SYNC_STAGES-1:0] ph_sh, rw_sh;
   logic ph_prev, ph_rise, ph_fall, rnw_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_sh   <= '0;
         rw_sh   <= '1;
         ph_prev <= 1'b0;
      end else begin
         ph_sh   <= {ph_sh[SYNC_STAGES-2:0], cpu_phi2};
         rw_sh   <= {rw_sh[SYNC_STAGES-2:0], cpu_rnw};
         ph_prev <= ph_sh[SYNC_STAGES-1];
      end
   end

   assign ph_rise = ph_sh[SYNC_STAGES-1] & ~ph_prev;
   assign ph_fall = ~ph_sh[SYNC_STAGES-1] & ph_prev;
   assign rnw_s   = rw_sh[SYNC_STAGES-1];

   // opcode family lookup
   fam_t in_fam;
   logic in_ok, accept;

   inj_opdecode u_dec (.op(host_op), .fam(in_fam));

   assign in_ok = (in_fam != FAM_NONE) && (host_len == fam_bytes(in_fam));

   // sequencer state
   seq_t       st;
   logic [PW-1:0] pre_cnt;
   logic [1:0] idle_cnt;
   logic       pend_v, rnw_cyc;
   fam_t       p_fam;
   logic [7:0] p_op, p_a0, p_a1, byte_nxt;
   logic [15:0] tag;
   logic       in_run, boundary;

   assign in_run     = !(st inside {S_RST, S_PRE, S_VLO, S_VHI});
   assign host_ready = !pend_v && cpu_rst_n && in_run;
   assign accept     = host_valid && host_ready;
   assign busy       = pend_v;
   assign boundary   = (st == S_IWR);

   inj_rst_timer #(.PERIOD(RST_PERIOD), .HOLD(RST_HOLD)) u_tmr (
      .clk(clk), .rst_n(rst_n), .cyc_end(ph_fall),
      .at_boundary(boundary), .cpu_rst_n(cpu_rst_n)
   );

   always_comb begin
      case (st)
         S_IZP:        byte_nxt = IDLE_ZP;
         S_VLO:        byte_nxt = VEC[7:0];
         S_VHI:        byte_nxt = VEC[15:8];
         S_OP:         byte_nxt = p_op;
         S_B1:         byte_nxt = p_a0;
         S_B2:         byte_nxt = p_a1;
         S_DAT, S_IWR: byte_nxt = cap_data;
         default:      byte_nxt = FILL_OP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_RST;      pre_cnt <= '0;    idle_cnt <= '0;
         pend_v <= 1'b0;   p_fam <= FAM_NONE;
         p_op <= '0;       p_a0 <= '0;       p_a1 <= '0;
         err <= 1'b0;      tag <= '0;        rnw_cyc <= 1'b1;
         cap_stb <= 1'b0;  cap_data <= '0;   cap_addr <= '0;
         cpu_d_oe <= 1'b0; cpu_d_out <= '0;
      end else begin
         cap_stb <= 1'b0;
         if (accept) begin
            if (in_ok) begin
               pend_v <= 1'b1; p_fam <= in_fam;
               p_op <= host_op; p_a0 <= host_arg0; p_a1 <= host_arg1;
               err <= 1'b0;
            end else begin
               err <= 1'b1;
            end
         end
         if (ph_rise) begin
            cpu_d_oe  <= rnw_s;
            cpu_d_out <= byte_nxt;
            rnw_cyc   <= rnw_s;
         end
         if (ph_fall) begin
            cpu_d_oe <= 1'b0;
            if (!rnw_cyc) begin
               cap_stb  <= 1'b1;
               cap_data <= cpu_d_in;
               cap_addr <= tag;
            end
         end
         if (!cpu_rst_n) begin
            st <= S_RST;
         end else if (ph_fall || st == S_RST) begin
            case (st)
               S_RST: begin st <= S_PRE; pre_cnt <= '0; idle_cnt <= '0; end
               S_PRE: begin
                  if (pre_cnt == PW'(PRE_CYC - 1)) st <= S_VLO;
                  else pre_cnt <= pre_cnt + 1'b1;
               end
               S_VLO: st <= S_VHI;
               S_VHI: st <= S_IOP;
               S_IOP: st <= S_IZP;
               S_IZP: begin st <= S_IWR; tag <= {8'h00, IDLE_ZP}; end
               S_IWR: begin
                  if (pend_v && idle_cnt != 2'd0) begin
                     st <= S_OP; idle_cnt <= '0;
                  end else begin
                     st <= S_IOP;
                     if (idle_cnt != 2'd2) idle_cnt <= idle_cnt + 1'b1;
                  end
               end
               S_OP: st <= S_B1;
               S_B1: begin
                  if (p_fam != FAM_IMM) tag <= {8'h00, p_a0};
                  if (p_fam == FAM_IMM) begin st <= S_IOP; pend_v <= 1'b0; end
                  else if (p_fam == FAM_ZP) st <= S_DAT;
                  else st <= S_B2;
               end
               S_B2:  begin st <= S_DAT; tag[15:8] <= p_a1; end
               S_DAT: begin st <= S_IOP; pend_v <= 1'b0; end
               default: st <= S_IOP;
            endcase
         end
      end
   end

   AST_RST_AT_FILL_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_rst_n) |-> $past(st) == S_IWR); // R11
   AST_RST_STOPS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_rst_n) |=> st == S_RST); // R11
   AST_WRITE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |-> !cpu_d_oe); // R4
   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> !cap_stb); // R4
   AST_BUSY_IN_HOST_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rst_n && st inside {S_B1, S_B2, S_DAT}) |-> busy); // R9
endmodule

// File: tb/tb_bus_injector.sv
module tb_bus_injector;
   localparam int          CLK_PERIOD = 10;
   localparam int unsigned PERIOD     = 60;
   localparam int unsigned HOLD       = 3;
   localparam int unsigned PRE        = 5;
   localparam logic [15:0] VEC        = 16'hC012;
   localparam logic [7:0]  IZP        = 8'h20;

   logic clk = 0, rst_n = 0;
   logic cpu_phi2 = 0, cpu_rnw = 1;
   logic [7:0] cpu_d_in = 0;
   logic [7:0] cpu_d_out;
   logic cpu_d_oe, cpu_rst_n;
   logic host_valid = 0, host_ready;
   logic [7:0] host_op = 0, host_arg0 = 0, host_arg1 = 0;
   logic [1:0] host_len = 0;
   logic busy, err, cap_stb;
   logic [7:0] cap_data;
   logic [15:0] cap_addr;

   bus_injector #(.SYNC_STAGES(2), .RST_PERIOD(PERIOD), .RST_HOLD(HOLD),
                  .PRE_CYC(PRE), .VEC(VEC), .IDLE_ZP(IZP)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_phi2(cpu_phi2), .cpu_rnw(cpu_rnw),
      .cpu_d_in(cpu_d_in), .cpu_d_out(cpu_d_out), .cpu_d_oe(cpu_d_oe),
      .cpu_rst_n(cpu_rst_n), .host_valid(host_valid), .host_ready(host_ready),
      .host_op(host_op), .host_arg0(host_arg0), .host_arg1(host_arg1),
      .host_len(host_len), .busy(busy), .err(err), .cap_stb(cap_stb),
      .cap_data(cap_data), .cap_addr(cap_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0, stb_cnt = 0, cyc_hi = 0, nidle = 0, nresets = 0;
   logic [7:0] acc = 8'h00, last_adr = 8'h00;

   always @(posedge clk) if (cap_stb) stb_cnt++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one CPU bus cycle: address phase, then data phase, then settle
   task automatic bus_cycle(input logic rnw, input logic [7:0] wd,
                            output logic [7:0] rd, output logic oe);
      if (cpu_rst_n) cyc_hi++;
      cpu_rnw = rnw; cpu_d_in = wd;
      repeat (4) @(negedge clk);
      cpu_phi2 = 1;
      repeat (6) @(negedge clk);
      rd = cpu_d_out; oe = cpu_d_oe;
      repeat (2) @(negedge clk);
      cpu_phi2 = 0;
      repeat (6) @(negedge clk);
   endtask

   task automatic wr_cycle(input logic [15:0] exp_tag);
      logic [7:0] b; logic oe; int s0;
      s0 = stb_cnt;
      bus_cycle(1'b0, acc, b, oe);
      chk(!oe, "R4 drivers off on write", oe, 0);
      chk(stb_cnt == s0 + 1, "R4 one capture strobe", stb_cnt - s0, 1);
      chk(cap_data == acc, "R4 captured byte", cap_data, acc);
      chk(cap_addr == exp_tag, "R4 address tag", cap_addr, exp_tag);
   endtask

   task automatic reset_seq();
      logic [7:0] b; logic oe; int n;
      if (nresets > 0)
         chk(cyc_hi >= PERIOD && cyc_hi <= PERIOD + 7, "R11 reset period window", cyc_hi, PERIOD);
      n = 0;
      while (!cpu_rst_n) begin
         chk(!host_ready, "R9 ready low in reset", host_ready, 0);
         bus_cycle(1'b1, 8'h00, b, oe);
         n++;
      end
      chk(n == HOLD, "R2 reset hold length", n, HOLD);
      cyc_hi = 0;
      for (int i = 0; i < PRE; i++) bus_cycle(1'b1, 8'h00, b, oe);
      bus_cycle(1'b1, 8'h00, b, oe);
      chk(oe && b == VEC[7:0], "R2 vector low", b, VEC[7:0]);
      bus_cycle(1'b1, 8'h00, b, oe);
      chk(oe && b == VEC[15:8], "R2 vector high", b, VEC[15:8]);
      nidle = 0;
      nresets++;
   endtask

   task automatic host_start();
      chk(nidle >= 2, "R8 filler gap before host instruction", nidle, 2);
      nidle = 0;
   endtask

   // bus-level CPU model with its own opcode decode and accumulator
   task automatic cpu_step(output logic [7:0] opc);
      logic [7:0] b, lo, hi; logic oe;
      if (!cpu_rst_n) reset_seq();
      bus_cycle(1'b1, 8'h00, opc, oe);
      chk(oe, "R3 opcode read driven", oe, 1);
      case (opc)
         8'h85: begin
            bus_cycle(1'b1, 8'h00, lo, oe);
            chk(lo == IZP, "R3 filler address", lo, IZP);
            wr_cycle({8'h00, lo});
            nidle++;
         end
         8'hA9, 8'h49: begin
            host_start();
            bus_cycle(1'b1, 8'h00, b, oe);
            chk(oe, "R5 operand driven", oe, 1);
            acc = (opc == 8'hA9) ? b : (acc ^ b);
         end
         8'hA5: begin
            host_start();
            bus_cycle(1'b1, 8'h00, lo, oe);
            last_adr = lo;
            bus_cycle(1'b1, 8'h00, b, oe);
            chk(oe, "R6 data read driven", oe, 1);
            acc = b;
         end
         8'h8D: begin
            host_start();
            bus_cycle(1'b1, 8'h00, lo, oe);
            bus_cycle(1'b1, 8'h00, hi, oe);
            wr_cycle({hi, lo});
         end
         default: chk(1'b0, "R10 unexpected opcode on bus", opc, 8'h85);
      endcase
   endtask

   task automatic host_issue(input logic [7:0] op, a0, a1, input logic [1:0] len);
      logic [7:0] o; int guard;
      guard = 0;
      while (!host_ready && guard < 80) begin cpu_step(o); guard++; end
      host_op = op; host_arg0 = a0; host_arg1 = a1; host_len = len;
      host_valid = 1;
      @(negedge clk);
      host_valid = 0;
   endtask

   task automatic run_until(input logic [7:0] want);
      logic [7:0] o; int guard;
      guard = 0;
      o = 8'h00;
      while (o != want && guard < 80) begin cpu_step(o); guard++; end
      chk(o == want, "R8 host instruction reached bus", o, want);
   endtask

   task automatic t_reset();
      logic [7:0] o;
      repeat (3) @(negedge clk);
      chk(!cpu_rst_n, "R1 cpu reset low", cpu_rst_n, 0);
      chk(!cpu_d_oe, "R1 drivers off", cpu_d_oe, 0);
      chk(!host_ready && !busy && !err, "R1 host side idle", {host_ready, busy, err}, 0);
      rst_n = 1;
      @(negedge clk);
      cpu_step(o);
   endtask

   task automatic t_idle();
      logic [7:0] o;
      for (int i = 0; i < 4; i++) begin
         cpu_step(o);
         chk(o == 8'h85, "R3 filler opcode", o, 8'h85);
      end
   endtask

   task automatic t_imm();
      logic [7:0] o;
      host_issue(8'hA9, 8'h01, 8'h00, 2'd2);
      host_issue(8'h49, 8'hFF, 8'h00, 2'd2);
      run_until(8'h49);
      cpu_step(o);
      if (o != 8'h85) cpu_step(o);
      chk(cap_data == 8'hFE, "R5 load then xor stores FE", cap_data, 8'hFE);
   endtask

   task automatic t_zp();
      host_issue(8'hA9, 8'h5A, 8'h00, 2'd2);
      host_issue(8'hA5, 8'h10, 8'h00, 2'd2);
      run_until(8'hA5);
      chk(last_adr == 8'h10, "R6 zero-page address byte", last_adr, 8'h10);
      chk(acc == 8'h5A, "R6 read returns last capture", acc, 8'h5A);
   endtask

   task automatic t_abs();
      host_issue(8'hA9, 8'hC3, 8'h00, 2'd2);
      host_issue(8'h8D, 8'h34, 8'h12, 2'd3);
      run_until(8'h8D);
      chk(cap_addr == 16'h1234, "R7 absolute tag", cap_addr, 16'h1234);
      chk(cap_data == 8'hC3, "R7 absolute store data", cap_data, 8'hC3);
   endtask

   task automatic t_busy();
      host_issue(8'hA9, 8'h77, 8'h00, 2'd2);
      chk(busy, "R9 busy after accept", busy, 1);
      chk(!host_ready, "R9 ready low while pending", host_ready, 0);
      run_until(8'hA9);
      chk(!busy, "R9 busy clears at last cycle", busy, 0);
      chk(acc == 8'h77, "R5 immediate operand", acc, 8'h77);
   endtask

   task automatic t_err();
      logic [7:0] o;
      host_issue(8'h02, 8'h00, 8'h00, 2'd2);
      chk(err, "R10 unknown opcode flagged", err, 1);
      chk(!busy && host_ready, "R10 request dropped", {busy, host_ready}, 1);
      for (int i = 0; i < 6; i++) begin
         cpu_step(o);
         chk(o == 8'h85, "R10 only filler after reject", o, 8'h85);
      end
      host_issue(8'hA9, 8'h00, 8'h00, 2'd3);
      chk(err && !busy, "R10 length mismatch flagged", {err, busy}, 2);
      host_issue(8'h49, 8'h00, 8'h00, 2'd2);
      chk(!err, "R10 valid request clears flag", err, 0);
      run_until(8'h49);
   endtask

   task automatic t_period();
      logic [7:0] o; int guard;
      guard = 0;
      while (nresets < 3 && guard < 200) begin cpu_step(o); guard++; end
      chk(nresets >= 3, "R11 periodic resets occur", nresets, 3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_idle();
      t_imm();
      t_zp();
      t_abs();
      t_busy();
      t_err();
      t_period();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule